// File: doc/BRIEF.md
# Flash Status-Bit Read Multiplexer

This block forms the word a host sees when it reads a dual-plane flash model while an embedded program or erase may be running. Every read names a plane and a sector. A read of a plane with no operation in progress returns the true array word, so one plane can be read while the other plane is written. A read of a plane that is working returns a status word instead: a data-polling bit, a toggle bit, and a second toggle bit that marks the sector under erase.

Reads are captured on the rising edge of a read strobe. The returned word is registered. It appears on the cycle after the rising edge and holds until the next captured read. Each plane has its own pair of toggle flip-flops. They advance only on captured reads that report them, so a strobe held high never toggles anything. An open-drain style ready/busy output pulls low while any plane is busy and is otherwise released high.

Top module: `flash_status_mux`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the read word is 0 and every toggle flip-flop is cleared. With no plane busy, ready/busy reads 1.
- R2: A read of a plane that is busy programming returns the following word: bit 7 is the inverse of bit 7 of the last loaded data, bit 6 is the toggle bit, bit 2 is 1, and all other bits are 0.
- R3: A read of a plane that is busy erasing returns 0 on bit 7 and the toggle bit on bit 6. Bit 2 is 1 unless the read hits the erase sector (R5). All other bits are 0.
- R4: Bit 6 of a status read from a busy plane reads 0 on the first such read of that plane after reset. It inverts on each later captured read of that plane. It does not advance on reads that return array data.
- R5: Bit 2 toggles on captured reads of the erase sector, both while the erase runs and while it is suspended. The first such read of a plane after reset gives 0.
- R6: A read of a plane that is not busy returns the array word unchanged, whatever the other plane is doing.
- R7: While an erase is suspended, a read of the erase sector returns 1 on bits 7 and 6, the erase toggle on bit 2, and 0 on all other bits. This takes priority over the plane's busy state. A read of any other sector of an idle plane returns true data.
- R8: A read is captured only on a cycle where the strobe is high and was low on the previous cycle. The word updates one cycle later and stays stable while the strobe is held or low.
- R9: Ready/busy is 0 in exactly those cycles where at least one plane is busy.
- R10: Once no plane is busy and no erase is suspended, the next read returns the full array word on all bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdStrobe | input | 1 | Read request; a read is taken on its rising edge |
| rdPlane | input | 1 | Plane index of the read address |
| rdSector | input | 5 | Global sector index of the read address |
| arrayData | input | 16 | True array word at the read address |
| planeBusy | input | 2 | Per-plane embedded operation in progress |
| planeIsErase | input | 2 | Per-plane operation type: 1 erase, 0 program |
| lastProgData | input | 16 | Data word most recently loaded for programming |
| suspendOn | input | 1 | An erase is suspended |
| eraseSector | input | 5 | Global index of the sector being or suspended from erasing |
| rdData | output | 16 | Registered read word |
| readyBusyN | output | 1 | Low while any plane is busy, released high otherwise |

## Verification
If a toggle flip-flop holds the wrong state, or advances on the wrong read, the fault shows on bit 6 or bit 2 of the very next status read of that plane. Because the bench steps a reference on every cycle, the error is caught on the cycle after that read's rising strobe. A wrong classification (status where data belongs, or the reverse, or program and erase polarity swapped) corrupts the whole word one cycle after the capturing edge. Stimulus therefore alternates reads between busy and idle planes, between erase and non-erase sectors, and in and out of suspension. It also holds the strobe high across several cycles.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;
  localparam int POLL_BIT = 7;
  localparam int TOGGLE_BIT = 6;
  localparam int ERASE_TOGGLE_BIT = 2;

  typedef enum logic [1:0] {
    RK_ARRAY = 2'd0,
    RK_PROG  = 2'd1,
    RK_ERASE = 2'd2,
    RK_SUSP  = 2'd3
  } readKind_e;

  typedef struct packed {
    logic      capture;
    readKind_e kind;
    logic      tog6;
    logic      tog2;
    logic      useTog2;
  } ctrlStrobe_t;
endpackage

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl
  import flash_status_pkg::*;
#(
  parameter int PLANES = 2,
  parameter int SECT_W = 5,
  localparam int PLANE_W = (PLANES > 1) ? $clog2(PLANES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rdStrobe,
  input  logic [PLANE_W-1:0] rdPlane,
  input  logic [SECT_W-1:0]  rdSector,
  input  logic [PLANES-1:0]  planeBusy,
  input  logic [PLANES-1:0]  planeIsErase,
  input  logic               suspendOn,
  input  logic [SECT_W-1:0]  eraseSector,
  output ctrlStrobe_t        strb
);
  logic              strobeQ;
  logic              capture;
  logic              sectorHit;
  readKind_e         kind;
  logic              useTog2;
  logic [PLANES-1:0] tog6Q;
  logic [PLANES-1:0] tog2Q;

  always_ff @(posedge clk) begin
    if (!rstN) strobeQ <= 1'b0;
    else       strobeQ <= rdStrobe;
  end

  assign capture   = rdStrobe & ~strobeQ;
  assign sectorHit = (rdSector == eraseSector);

  always_comb begin
    if (suspendOn && sectorHit)   kind = RK_SUSP;
    else if (planeBusy[rdPlane])  kind = planeIsErase[rdPlane] ? RK_ERASE : RK_PROG;
    else                          kind = RK_ARRAY;
  end

  assign useTog2 = (kind == RK_SUSP) || ((kind == RK_ERASE) && sectorHit);

  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    logic selHere;
    assign selHere = capture && (rdPlane == PLANE_W'(p));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        tog6Q[p] <= 1'b0;
        tog2Q[p] <= 1'b0;
      end else begin
        if (selHere && ((kind == RK_PROG) || (kind == RK_ERASE))) tog6Q[p] <= ~tog6Q[p];
        if (selHere && useTog2) tog2Q[p] <= ~tog2Q[p];
      end
    end
  end

  assign strb.capture = capture;
  assign strb.kind    = kind;
  assign strb.tog6    = tog6Q[rdPlane];
  assign strb.tog2    = tog2Q[rdPlane];
  assign strb.useTog2 = useTog2;

  // R8
  hold_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdStrobe |=> $stable(tog6Q) && $stable(tog2Q));

  // R4
  idle_no_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (planeBusy == '0) && !suspendOn |=> $stable(tog6Q) && $stable(tog2Q));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> (tog6Q == '0) && (tog2Q == '0));
endmodule

// File: rtl/flash_status_data.sv
module flash_status_data
  import flash_status_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [DATA_W-1:0] arrayData,
  input  logic [DATA_W-1:0] lastProgData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] nextWord;

  always_comb begin
    nextWord = '0;
    unique case (strb.kind)
      RK_ARRAY: nextWord = arrayData;
      RK_PROG: begin
        nextWord[POLL_BIT]         = ~lastProgData[POLL_BIT];
        nextWord[TOGGLE_BIT]       = strb.tog6;
        nextWord[ERASE_TOGGLE_BIT] = 1'b1;
      end
      RK_ERASE: begin
        nextWord[POLL_BIT]         = 1'b0;
        nextWord[TOGGLE_BIT]       = strb.tog6;
        nextWord[ERASE_TOGGLE_BIT] = strb.useTog2 ? strb.tog2 : 1'b1;
      end
      RK_SUSP: begin
        nextWord[POLL_BIT]         = 1'b1;
        nextWord[TOGGLE_BIT]       = 1'b1;
        nextWord[ERASE_TOGGLE_BIT] = strb.tog2;
      end
      default: nextWord = arrayData;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)             rdData <= '0;
    else if (strb.capture) rdData <= nextWord;
  end

  // R8
  word_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(rdData));

  // R3
  erase_poll_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture && (strb.kind == RK_ERASE) |=> !rdData[POLL_BIT]);

  // R7
  susp_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture && (strb.kind == RK_SUSP) |=> rdData[POLL_BIT] && rdData[TOGGLE_BIT]);

  // R6
  array_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture && (strb.kind == RK_ARRAY) |=> rdData == $past(arrayData));

  // R1
  reset_word_chk: assert property (@(posedge clk)
    !rstN |=> rdData == '0);
endmodule

// File: rtl/flash_status_mux.sv
module flash_status_mux
  import flash_status_pkg::*;
#(
  parameter int PLANES = 2,
  parameter int SECT_W = 5,
  parameter int DATA_W = 16,
  localparam int PLANE_W = (PLANES > 1) ? $clog2(PLANES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rdStrobe,
  input  logic [PLANE_W-1:0] rdPlane,
  input  logic [SECT_W-1:0]  rdSector,
  input  logic [DATA_W-1:0]  arrayData,
  input  logic [PLANES-1:0]  planeBusy,
  input  logic [PLANES-1:0]  planeIsErase,
  input  logic [DATA_W-1:0]  lastProgData,
  input  logic               suspendOn,
  input  logic [SECT_W-1:0]  eraseSector,
  output logic [DATA_W-1:0]  rdData,
  output logic               readyBusyN
);
  ctrlStrobe_t strb;

  flash_status_ctrl #(.PLANES(PLANES), .SECT_W(SECT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .rdPlane(rdPlane),
    .rdSector(rdSector), .planeBusy(planeBusy), .planeIsErase(planeIsErase),
    .suspendOn(suspendOn), .eraseSector(eraseSector), .strb(strb)
  );

  flash_status_data #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .arrayData(arrayData),
    .lastProgData(lastProgData), .rdData(rdData)
  );

  // Open-drain style: only ever pulls low while work is in progress.
  assign readyBusyN = (planeBusy == '0);

  // R9
  ready_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(|planeBusy) |-> readyBusyN);
endmodule

// File: tb/flash_status_mux_bench.sv
`timescale 1ns/1ps
module flash_status_mux_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        rdStrobe;
  logic [0:0]  rdPlane;
  logic [4:0]  rdSector;
  logic [15:0] arrayData;
  logic [1:0]  planeBusy;
  logic [1:0]  planeIsErase;
  logic [15:0] lastProgData;
  logic        suspendOn;
  logic [4:0]  eraseSector;
  logic [15:0] rdData;
  logic        readyBusyN;

  always #2 clk = ~clk;

  flash_status_mux u_flash_status_mux (
    .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .rdPlane(rdPlane),
    .rdSector(rdSector), .arrayData(arrayData), .planeBusy(planeBusy),
    .planeIsErase(planeIsErase), .lastProgData(lastProgData),
    .suspendOn(suspendOn), .eraseSector(eraseSector),
    .rdData(rdData), .readyBusyN(readyBusyN)
  );

  int vectors = 0;
  int misses = 0;
  bit finished = 0;
  bit mTog6 [2];
  bit mTog2 [2];
  bit mPrevStb;
  logic [15:0] expData;
  bit expReady;
  string expTag;

  // Behavioural reference: one step per clock, using the inputs now applied.
  task automatic modelStep();
    int p;
    bit hit;
    if (!rstN) begin
      expData = 16'h0; mTog6 = '{0, 0}; mTog2 = '{0, 0}; mPrevStb = 0; expTag = "R1";
    end else begin
      if (rdStrobe && !mPrevStb) begin
        p = int'(rdPlane);
        hit = (rdSector == eraseSector);
        if (suspendOn && hit) begin
          expData = 16'h00C0;
          expData[2] = mTog2[p];
          mTog2[p] = !mTog2[p];
          expTag = "R7/R5";
        end else if (planeBusy[p]) begin
          expData = 16'h0;
          expData[6] = mTog6[p];
          mTog6[p] = !mTog6[p];
          if (planeIsErase[p]) begin
            if (hit) begin
              expData[2] = mTog2[p]; mTog2[p] = !mTog2[p]; expTag = "R3/R5";
            end else begin
              expData[2] = 1'b1; expTag = "R3/R4";
            end
          end else begin
            expData[7] = !lastProgData[7];
            expData[2] = 1'b1;
            expTag = "R2/R4";
          end
        end else begin
          expData = arrayData;
          expTag = ((planeBusy == 2'b00) && !suspendOn) ? "R10" : "R6";
        end
      end else if (rdStrobe) begin
        expTag = "R8";
      end
      mPrevStb = rdStrobe;
    end
    expReady = (planeBusy == 2'b00);
  endtask

  task automatic cyc();
    modelStep();
    @(negedge clk);
    vectors++;
    if (rdData !== expData) begin
      misses++;
      $display("FAIL %s rdData actual=%h expected=%h", expTag, rdData, expData);
    end
    vectors++;
    if (readyBusyN !== expReady) begin
      misses++;
      $display("FAIL R9 readyBusyN actual=%b expected=%b", readyBusyN, expReady);
    end
  endtask

  task automatic setRead(input int sect);
    rdSector = 5'(sect);
    rdPlane = (sect < 8) ? 1'b0 : 1'b1;
    arrayData = 16'($urandom);
  endtask

  // One captured read: strobe high one cycle, then low one cycle.
  task automatic doRead(input int sect);
    setRead(sect);
    rdStrobe = 1'b1; cyc();
    rdStrobe = 1'b0; cyc();
  endtask

  initial begin
    rstN = 0; rdStrobe = 0; rdPlane = 0; rdSector = 0; arrayData = 16'h1234;
    planeBusy = 0; planeIsErase = 0; lastProgData = 16'h0; suspendOn = 0; eraseSector = 0;
    // R1 reset state, strobe pulsed during reset must not capture
    cyc(); rdStrobe = 1; cyc(); rdStrobe = 0; cyc();
    rstN = 1; cyc();
    // R6 idle reads
    doRead(3); doRead(15);
    // R2 R4 program in plane 0, loaded data bit7 = 1 then 0
    planeBusy = 2'b01; planeIsErase = 2'b00; lastProgData = 16'h00A5;
    doRead(2); doRead(5); doRead(1);
    lastProgData = 16'h0042; doRead(0);
    // R6 other plane readable while plane 0 programs
    doRead(20); doRead(9);
    // R8 held strobe: one capture only
    setRead(4); rdStrobe = 1; cyc(); cyc(); cyc(); arrayData = 16'hFFFF; cyc();
    rdStrobe = 0; cyc(); cyc();
    // R3 R5 erase sector 12 of plane 1
    planeBusy = 2'b10; planeIsErase = 2'b10; eraseSector = 5'd12;
    doRead(12); doRead(13); doRead(12); doRead(12); doRead(6);
    // R7 suspend: erase sector gives status, others true data
    planeBusy = 2'b00; suspendOn = 1;
    doRead(12); doRead(14); doRead(12);
    // R7 program another sector during suspension
    planeBusy = 2'b10; planeIsErase = 2'b00; lastProgData = 16'h0080;
    doRead(11); doRead(12); doRead(3);
    // R10 all finished
    planeBusy = 2'b00; suspendOn = 0;
    doRead(12); doRead(2);
    // mixed patterns
    for (int i = 0; i < 3000; i++) begin
      if ((i % 16) == 0) begin
        planeBusy = 2'($urandom);
        planeIsErase = 2'($urandom);
        lastProgData = 16'($urandom);
        suspendOn = (($urandom % 4) == 0);
        eraseSector = 5'($urandom % 22);
      end
      setRead(int'($urandom % 22));
      if (($urandom % 3) == 0) setRead(int'(eraseSector));
      rdStrobe = ($urandom % 2) == 1;
      cyc();
    end
    // R1 reset again mid-run
    rstN = 0; cyc(); rstN = 1; cyc();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!finished) begin
      finished = 1;
      misses++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule